// File: doc/BRIEF.md
# Single-Word DMA Copy Controller

This block is a small bus master that moves one word from a peripheral data register into memory when the peripheral raises its interrupt. The processor takes no part in the data movement. Its only role is to grant the shared bus. The controller asks the processor for the bus. Once the grant arrives, it becomes bus master and acknowledges the peripheral. It reads the word from a fixed source address into an internal holding register. It then writes that word to a fixed destination address and gives the bus back.

The bus outputs behave like tri-state drivers modelled as logic. Address, write data and both strobes are zero whenever the controller is not the owner. After a transfer ends, the controller waits for the processor to drop its grant before it raises a new request. An interrupt that is still pending at that point starts a new transfer.

Top module: `dma_copy_ctrl`

## Requirements
- R1: While `rst_ni` is low, every output is 0: request, acknowledge, ownership, strobes, address and write data. The controller is idle when reset is released.
- R2: When the controller is idle, a high `irq_i` at a clock edge raises `bus_req_o` after that edge. While the grant is still missing, `bus_own_o`, `irq_ack_o`, `rd_o`, `wr_o`, `addr_o` and `wdata_o` all stay 0.
- R3: When `bus_gnt_i` is high at an edge while the request is pending, the following three outputs all go high after that edge: `bus_own_o`, `irq_ack_o`, and `rd_o` with `addr_o` = `SRC_ADDR` (default 0x00002000).
- R4: `rd_o` and the source address stay asserted until `rvalid_i` is seen in a cycle after the first read cycle. A `rvalid_i` during the first read cycle, the one right after the grant, is ignored.
- R5: The controller captures `rdata_i` at the edge where R4's `rvalid_i` is seen. After that edge, `rd_o` falls and `wr_o` rises with `addr_o` = `DST_ADDR` (default 0x00003000) and `wdata_o` = the captured word. These hold unchanged while `wready_i` is low, and later `rdata_i` values have no effect on them.
- R6: When `wready_i` is high at an edge during the write, `bus_req_o` and `irq_ack_o` fall together after that edge. Ownership and all bus lines fall at the same time.
- R7: After a release, `bus_req_o` stays low, even with `irq_i` high, until `bus_gnt_i` has been sampled low.
- R8: Whenever `bus_own_o` is 0, `addr_o`, `wdata_o`, `rd_o` and `wr_o` are 0.
- R9: If `irq_i` is still high once the grant has been seen low after a release, a new request is raised. The transfer that follows reads the new source word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Service request from the peripheral |
| bus_req_o | output | 1 | Bus request to the processor |
| bus_gnt_i | input | 1 | Bus grant from the processor |
| irq_ack_o | output | 1 | Acknowledge to the peripheral |
| bus_own_o | output | 1 | High while this block masters the bus |
| addr_o | output | AW | Bus address, zero when not owner |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| wdata_o | output | DW | Write data, zero when not owner |
| rdata_i | input | DW | Read data from the addressed slave |
| rvalid_i | input | 1 | Read data valid from the slave |
| wready_i | input | 1 | Write accepted by the slave |

## Verification
Every result is registered exactly once, so each response appears one clock edge after the input that causes it. This covers the request after `irq_i`, the read phase after the grant, the write phase after `rvalid_i`, the release after `wready_i`, and the return to idle after the grant falls. The bench applies each vector on the falling edge and checks the outputs just after the next rising edge, so it always compares the state that edge produced. The one exception is reset: it is asynchronous, so its zeroed outputs are checked a moment after `rst_ni` falls, in the middle of a clock cycle.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQ      = 3'd1,
    ST_RD       = 3'd2,
    ST_RD_WAIT  = 3'd3,
    ST_WR       = 3'd4,
    ST_REL      = 3'd5,
    ST_GNT_LOW  = 3'd6
  } copy_state_e;
endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_copy_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic gnt_i,
  input  logic rvalid_i,
  input  logic wready_i,
  output logic req_o,
  output logic own_o,
  output logic rd_ph_o,
  output logic wr_ph_o,
  output logic cap_o
);
  copy_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (irq_i)    state_d = ST_REQ;
      ST_REQ:     if (gnt_i)    state_d = ST_RD;
      ST_RD:                    state_d = ST_RD_WAIT;  // address phase, rvalid not sampled
      ST_RD_WAIT: if (rvalid_i) state_d = ST_WR;
      ST_WR:      if (wready_i) state_d = ST_REL;
      ST_REL:                   state_d = ST_GNT_LOW;
      ST_GNT_LOW: if (!gnt_i)   state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_o   = (state_q == ST_REQ) || (state_q == ST_RD) ||
                   (state_q == ST_RD_WAIT) || (state_q == ST_WR);
  assign own_o   = (state_q == ST_RD) || (state_q == ST_RD_WAIT) || (state_q == ST_WR);
  assign rd_ph_o = (state_q == ST_RD) || (state_q == ST_RD_WAIT);
  assign wr_ph_o = (state_q == ST_WR);
  assign cap_o   = (state_q == ST_RD_WAIT) && rvalid_i;
endmodule

// File: rtl/dma_hold_buf.sv
module dma_hold_buf #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dout_o <= '0;
    else if (cap_i) dout_o <= din_i;
  end
endmodule

// File: rtl/dma_bus_drv.sv
module dma_bus_drv #(
  parameter int              AW       = 32,
  parameter int              DW       = 32,
  parameter logic [AW-1:0]   SRC_ADDR = 'h2000,
  parameter logic [AW-1:0]   DST_ADDR = 'h3000
) (
  input  logic          own_i,
  input  logic          rd_ph_i,
  input  logic          wr_ph_i,
  input  logic [DW-1:0] buf_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          rd_o,
  output logic          wr_o
);
  // lines read as zero when another master owns the bus
  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    rd_o    = 1'b0;
    wr_o    = 1'b0;
    if (own_i) begin
      if (wr_ph_i) begin
        addr_o  = DST_ADDR;
        wdata_o = buf_i;
        wr_o    = 1'b1;
      end else if (rd_ph_i) begin
        addr_o  = SRC_ADDR;
        rd_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_copy_ctrl.sv
module dma_copy_ctrl #(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter logic [AW-1:0] SRC_ADDR = 'h2000,
  parameter logic [AW-1:0] DST_ADDR = 'h3000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          irq_ack_o,
  output logic          bus_own_o,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  input  logic          rvalid_i,
  input  logic          wready_i
);
  logic          own, rd_ph, wr_ph, cap;
  logic [DW-1:0] hold;

  dma_seq_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .gnt_i    (bus_gnt_i),
    .rvalid_i (rvalid_i),
    .wready_i (wready_i),
    .req_o    (bus_req_o),
    .own_o    (own),
    .rd_ph_o  (rd_ph),
    .wr_ph_o  (wr_ph),
    .cap_o    (cap)
  );

  dma_hold_buf #(.DW(DW)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .din_i  (rdata_i),
    .dout_o (hold)
  );

  dma_bus_drv #(.AW(AW), .DW(DW), .SRC_ADDR(SRC_ADDR), .DST_ADDR(DST_ADDR)) u_drv (
    .own_i   (own),
    .rd_ph_i (rd_ph),
    .wr_ph_i (wr_ph),
    .buf_i   (hold),
    .addr_o  (addr_o),
    .wdata_o (wdata_o),
    .rd_o    (rd_o),
    .wr_o    (wr_o)
  );

  assign bus_own_o = own;
  assign irq_ack_o = own;  // peripheral acknowledged for exactly the mastership window
endmodule

// File: rtl/dma_copy_ctrl_chk.sv
module dma_copy_ctrl_chk #(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter logic [AW-1:0] SRC_ADDR = 'h2000,
  parameter logic [AW-1:0] DST_ADDR = 'h3000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_i,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic          irq_ack_o,
  input logic          bus_own_o,
  input logic [AW-1:0] addr_o,
  input logic          rd_o,
  input logic          wr_o,
  input logic [DW-1:0] wdata_o,
  input logic          rvalid_i,
  input logic          wready_i
);
  a_r2_req_from_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(irq_i) && !bus_own_o);

  a_r3_own_after_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_own_o) |-> $past(bus_gnt_i) && bus_req_o && rd_o && addr_o == SRC_ADDR);

  a_r4_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_o) |-> $past(rvalid_i) && wr_o);

  a_r5_wdata_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o && $past(wr_o) |-> $stable(wdata_o) && addr_o == DST_ADDR);

  a_r6_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> !irq_ack_o && !bus_own_o && $past(wr_o && wready_i));

  a_r7_req_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |=> !bus_req_o);

  a_r8_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_own_o |-> addr_o == '0 && wdata_o == '0 && !rd_o && !wr_o);
endmodule

bind dma_copy_ctrl dma_copy_ctrl_chk #(
  .AW(AW), .DW(DW), .SRC_ADDR(SRC_ADDR), .DST_ADDR(DST_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_i     (irq_i),
  .bus_req_o (bus_req_o),
  .bus_gnt_i (bus_gnt_i),
  .irq_ack_o (irq_ack_o),
  .bus_own_o (bus_own_o),
  .addr_o    (addr_o),
  .rd_o      (rd_o),
  .wr_o      (wr_o),
  .wdata_o   (wdata_o),
  .rvalid_i  (rvalid_i),
  .wready_i  (wready_i)
);

// File: tb/dma_copy_ctrl_bench.sv
module dma_copy_ctrl_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] SRC = 32'h0000_2000;
  localparam logic [31:0] DST = 32'h0000_3000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          irq_i = 1'b0, bus_gnt_i = 1'b0, rvalid_i = 1'b0, wready_i = 1'b0;
  logic [DW-1:0] rdata_i = '0;
  logic          bus_req_o, irq_ack_o, bus_own_o, rd_o, wr_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] wdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  dma_copy_ctrl u_dma_copy_ctrl (
    .clk_i, .rst_ni, .irq_i, .bus_req_o, .bus_gnt_i, .irq_ack_o, .bus_own_o,
    .addr_o, .rd_o, .wr_o, .wdata_o, .rdata_i, .rvalid_i, .wready_i
  );

  typedef struct packed {
    logic        irq, gnt, rv, wrdy;
    logic [31:0] rdata;
    logic        req, ack, own, rd, wr;
    logic [31:0] addr, wdata;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 20;
  // inputs applied before an edge, outputs expected after it
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd1}, // R1 idle
    '{1'b1,1'b0,1'b0,1'b0, 32'h0,         1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd2}, // R2 request
    '{1'b1,1'b0,1'b0,1'b0, 32'h0,         1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd2}, // R2 no drive
    '{1'b1,1'b1,1'b0,1'b0, 32'h0,         1'b1,1'b1,1'b1,1'b1,1'b0, SRC,   32'h0,         8'd3}, // R3 read
    '{1'b1,1'b1,1'b1,1'b0, 32'hDEAD_BEEF, 1'b1,1'b1,1'b1,1'b1,1'b0, SRC,   32'h0,         8'd4}, // R4 early rvalid ignored
    '{1'b1,1'b1,1'b0,1'b0, 32'h0,         1'b1,1'b1,1'b1,1'b1,1'b0, SRC,   32'h0,         8'd4}, // R4 hold
    '{1'b1,1'b1,1'b1,1'b0, 32'hA5A5_1234, 1'b1,1'b1,1'b1,1'b0,1'b1, DST,   32'hA5A5_1234, 8'd5}, // R5 write
    '{1'b1,1'b1,1'b1,1'b0, 32'h1111_2222, 1'b1,1'b1,1'b1,1'b0,1'b1, DST,   32'hA5A5_1234, 8'd5}, // R5 buffer kept
    '{1'b1,1'b1,1'b0,1'b1, 32'h0,         1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd6}, // R6 release
    '{1'b1,1'b1,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd7}, // R7
    '{1'b1,1'b1,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd7}, // R7 grant still high
    '{1'b1,1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd7}, // R7 back to idle
    '{1'b1,1'b0,1'b0,1'b0, 32'h0,         1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd9}, // R9 fresh request
    '{1'b1,1'b1,1'b0,1'b0, 32'h0,         1'b1,1'b1,1'b1,1'b1,1'b0, SRC,   32'h0,         8'd9}, // R9 read
    '{1'b0,1'b1,1'b0,1'b0, 32'h0,         1'b1,1'b1,1'b1,1'b1,1'b0, SRC,   32'h0,         8'd4},
    '{1'b0,1'b1,1'b1,1'b0, 32'h0F0F_00FF, 1'b1,1'b1,1'b1,1'b0,1'b1, DST,   32'h0F0F_00FF, 8'd9}, // R9 new word
    '{1'b0,1'b1,1'b0,1'b1, 32'h0,         1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd6},
    '{1'b0,1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd8}, // R8
    '{1'b0,1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd8},
    '{1'b0,1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0,         8'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input int rq, input vec_t v);
    string t;
    t = $sformatf("R%0d", rq);
    chk({t, " req"},   32'(bus_req_o), 32'(v.req));
    chk({t, " ack"},   32'(irq_ack_o), 32'(v.ack));
    chk({t, " own"},   32'(bus_own_o), 32'(v.own));
    chk({t, " rd"},    32'(rd_o),      32'(v.rd));
    chk({t, " wr"},    32'(wr_o),      32'(v.wr));
    chk({t, " addr"},  addr_o,         v.addr);
    chk({t, " wdata"}, wdata_o,        v.wdata);
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk_i);
    irq_i = v.irq; bus_gnt_i = v.gnt; rvalid_i = v.rv; wready_i = v.wrdy; rdata_i = v.rdata;
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    chk_all(1, '0);  // R1 outputs under reset
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      chk_all(int'(VEC[i].rq), VEC[i]);
    end

    // R1: asynchronous reset in the middle of a read
    drive('{1'b1,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,8'd1});
    drive('{1'b1,1'b1,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,8'd1});
    chk("R3 directed rd", 32'(rd_o), 32'd1);
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1;
    chk_all(1, '0);
    @(negedge clk_i);
    irq_i = 1'b0; bus_gnt_i = 1'b0;
    rst_ni = 1'b1;
    @(posedge clk_i);
    #2;
    chk_all(1, '0);  // R1 idle after reset release

    // R8: slave activity while not owner changes nothing
    drive('{1'b0,1'b0,1'b1,1'b1,32'hFFFF_FFFF,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,8'd8});
    chk_all(8, '0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule